// File: doc/BRIEF.md
# Raster Scan Waveform Sequencer

This block produces the digital drive codes for a pair of scan mirrors (galvanometer or voice-coil). The two codes go to two 16-bit DACs, and the mirrors trace a raster pattern. The horizontal (fast) axis sweeps across the imaging region one sample per update. Each sample code is taken from a writable correction table indexed by the nominal position, which removes residual actuator nonlinearity. After the last sample of a line, a flyback segment moves the code back to the start of the line as a straight ramp. This keeps the slew into the inductive load bounded. The vertical (slow) axis moves by a programmable step each time a line completes.

All motion advances on a tick-enable input, not on every clock. The block gives the acquisition engine a line marker, a frame marker and an imaging flag. With these, samples are taken only on the linear part of each line. Software sets the samples per line, the lines per frame, the flyback length and the vertical start and step. It loads the correction table while the scan is idle. A stop request is deferred until the current frame ends. The mirrors then park at the start position.

Top module: `raster_scan_seq`

## Requirements
- R1: After reset the block is idle. `running`, `img_active`, `line_sync` and `frame_sync` are low, and `y_code` equals `y_start`. The correction table holds the identity map (entry i = i·64), so `x_code` reads 0.
- R2: While imaging, each tick advances the pixel index p from 0 to `pix_last` and `x_code` shows table entry p. A line has `pix_last`+1 imaging samples.
- R3: After the last sample the line enters flyback for 2^`fly_sh` ticks. At flyback step k (1..2^`fly_sh`), `x_code` = L + floor((F−L)·k / 2^`fly_sh`), where L is table entry `pix_last` and F is table entry 0.
- R4: `line_sync` is high for exactly the update interval of pixel 0 of every line. `frame_sync` is high only during pixel 0 of line 0.
- R5: `img_active` is high during imaging samples only. It is low during flyback and idle.
- R6: During line l of a frame, `y_code` = (`y_start` + l·`y_step`) mod 2^16. Line l runs from 0 to `line_last`. The value changes when the next line's first sample begins.
- R7: A table write (`cal_we` with `cal_addr`, `cal_data`) is accepted only while idle. A write during a scan is ignored and leaves the entry unchanged for later frames.
- R8: On a clock without `tick`, the scan state and sync outputs stay unchanged.
- R9: A `stop_req` pulse during a frame lets that frame finish. The tick after the final flyback step returns the block to idle, with `y_code` = `y_start` and `x_code` = table entry 0. Otherwise frames repeat from line 0.
- R10: A scan starts only on a tick while idle with `start` high and `stop_req` low. The first sample is pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update enable; one scan step per tick |
| start | input | 1 | Begin scanning (sampled on tick while idle) |
| stop_req | input | 1 | Request stop at end of current frame |
| pix_last | input | 10 | Samples per line minus one |
| line_last | input | 10 | Lines per frame minus one |
| fly_sh | input | 3 | Flyback length is 2^fly_sh ticks |
| y_start | input | 16 | Vertical code of line 0 and park position |
| y_step | input | 16 | Vertical increment per line |
| cal_we | input | 1 | Correction table write strobe |
| cal_addr | input | 10 | Correction table address |
| cal_data | input | 16 | Correction table write data |
| x_code | output | 16 | Horizontal DAC code, offset binary |
| y_code | output | 16 | Vertical DAC code, offset binary |
| line_sync | output | 1 | First sample of a line |
| frame_sync | output | 1 | First sample of a frame |
| img_active | output | 1 | Current sample is on the linear imaging segment |
| running | output | 1 | Scan in progress |

## Verification
The assertions assume that `pix_last`, `line_last`, `fly_sh`, `y_start` and `y_step` are held constant while `running` is high. The vertical-step property relies on this. They also assume that `start` and `stop_req` are never raised on the same tick. The stimulus chooses each geometry at random from a fixed seed while the block is idle and changes it only after the stop completes. It pulses `stop_req` only on clocks without a tick, and it inserts random idle clocks between ticks so that the hold behaviour is exercised. Directed cases cover the full 1024-sample line, a one-sample line and the longest flyback.

// File: rtl/raster_scan_seq.sv
module raster_scan_seq #(
  parameter int CODE_W = 16,
  parameter int AW     = 10,
  parameter int LINE_W = 10,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              stop_req,
  input  logic [AW-1:0]     pix_last,
  input  logic [LINE_W-1:0] line_last,
  input  logic [SH_W-1:0]   fly_sh,
  input  logic [CODE_W-1:0] y_start,
  input  logic [CODE_W-1:0] y_step,
  input  logic              cal_we,
  input  logic [AW-1:0]     cal_addr,
  input  logic [CODE_W-1:0] cal_data,
  output logic [CODE_W-1:0] x_code,
  output logic [CODE_W-1:0] y_code,
  output logic              line_sync,
  output logic              frame_sync,
  output logic              img_active,
  output logic              running
);
  localparam int DEPTH = 1 << AW;
  localparam int K_W   = 1 << SH_W;
  localparam int PW    = CODE_W + K_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_IMG, S_FLY} phase_t;

  phase_t            phase;
  logic [AW-1:0]     pix;
  logic [LINE_W-1:0] line;
  logic [K_W-1:0]    k;
  logic              stop_pend;
  logic [CODE_W-1:0] y_q;
  logic [CODE_W-1:0] cal [DEPTH];

  logic [CODE_W-1:0] first_code, last_code, fly_code;
  logic signed [PW-1:0] diff_x, k_x, last_x, prod, step_x;
  logic [K_W-1:0] k_end;

  assign first_code = cal[0];
  assign last_code  = cal[pix_last];
  assign last_x     = PW'({1'b0, last_code});
  assign diff_x     = PW'({1'b0, first_code}) - last_x;
  assign k_x        = PW'({1'b0, k});
  assign prod       = diff_x * k_x;
  assign step_x     = prod >>> fly_sh;
  assign fly_code   = CODE_W'(last_x + step_x);
  assign k_end      = K_W'(1) << fly_sh;

  assign running    = (phase != S_IDLE);
  assign img_active = (phase == S_IMG);
  assign line_sync  = img_active && (pix == '0);
  assign frame_sync = line_sync && (line == '0);
  assign y_code     = running ? y_q : y_start;
  assign x_code     = (phase == S_FLY) ? fly_code :
                      (phase == S_IMG) ? cal[pix] : first_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cal[i] <= CODE_W'(i) << (CODE_W - AW);
    end else if (cal_we && phase == S_IDLE) begin
      cal[cal_addr] <= cal_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= S_IDLE;
      pix       <= '0;
      line      <= '0;
      k         <= '0;
      stop_pend <= 1'b0;
      y_q       <= '0;
    end else begin
      if (phase == S_IDLE) stop_pend <= 1'b0;
      else if (stop_req)   stop_pend <= 1'b1;
      if (tick) begin
        case (phase)
          S_IDLE: if (start && !stop_req) begin
            phase <= S_IMG;
            pix   <= '0;
            line  <= '0;
            y_q   <= y_start;
          end
          S_IMG: if (pix == pix_last) begin
            phase <= S_FLY;
            k     <= K_W'(1);
          end else begin
            pix <= pix + AW'(1);
          end
          S_FLY: if (k != k_end) begin
            k <= k + K_W'(1);
          end else begin
            phase <= S_IMG;
            pix   <= '0;
            if (line == line_last) begin
              line <= '0;
              y_q  <= y_start;
              if (stop_pend || stop_req) phase <= S_IDLE;
            end else begin
              line <= line + LINE_W'(1);
              y_q  <= y_q + y_step;
            end
          end
          default: phase <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/raster_scan_chk.sv
module raster_scan_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              running,
  input logic              img_active,
  input logic              line_sync,
  input logic              frame_sync,
  input logic [CODE_W-1:0] y_code,
  input logic [CODE_W-1:0] y_start,
  input logic [CODE_W-1:0] y_step
);
  assert_frame_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> line_sync && img_active);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !img_active && !line_sync && !frame_sync);

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    running && !tick |=> $stable({running, img_active, line_sync, frame_sync, y_code}));

  assert_park_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> y_code == y_start);

  assert_y_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_sync) && !frame_sync && $past(running) |-> y_code == CODE_W'($past(y_code) + y_step));
endmodule

bind raster_scan_seq raster_scan_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .running(running),
  .img_active(img_active), .line_sync(line_sync), .frame_sync(frame_sync),
  .y_code(y_code), .y_start(y_start), .y_step(y_step)
);

// File: tb/sim_raster_scan_seq.sv
module sim_raster_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, start = 1'b0, stop_req = 1'b0;
  logic [9:0]  pix_last = '0, line_last = '0;
  logic [2:0]  fly_sh = '0;
  logic [15:0] y_start = 16'h8000, y_step = 16'h0100;
  logic        cal_we = 1'b0;
  logic [9:0]  cal_addr = '0;
  logic [15:0] cal_data = '0;
  logic [15:0] x_code, y_code;
  logic        line_sync, frame_sync, img_active, running;

  int errors = 0, checks = 0;
  bit done = 0;
  int cal_m [1024];

  always #10 clk = ~clk;

  raster_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop_req(stop_req),
    .pix_last(pix_last), .line_last(line_last), .fly_sh(fly_sh),
    .y_start(y_start), .y_step(y_step), .cal_we(cal_we), .cal_addr(cal_addr),
    .cal_data(cal_data), .x_code(x_code), .y_code(y_code), .line_sync(line_sync),
    .frame_sync(frame_sync), .img_active(img_active), .running(running)
  );

  function automatic int exp_fly(int last, int first, int k, int sh);
    int d;
    d = first - last;
    return last + ((d * k) >>> sh);
  endfunction

  function automatic int exp_y(int l);
    return (int'(y_start) + l * int'(y_step)) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic write_cal(int a, int d);
    @(negedge clk) begin cal_we = 1'b1; cal_addr = 10'(a); cal_data = 16'(d); end
    @(negedge clk) cal_we = 1'b0;
    cal_m[a] = d;
  endtask

  task automatic run_cfg(int pl, int ll, int sh, int nf);
    int ex;
    pix_last = 10'(pl); line_last = 10'(ll); fly_sh = 3'(sh);
    @(negedge clk) start = 1'b1;
    tick_once();
    start = 1'b0;
    for (int f = 0; f < nf; f++) begin
      for (int l = 0; l <= ll; l++) begin
        for (int p = 0; p <= pl; p++) begin
          if (!(f == 0 && l == 0 && p == 0)) tick_once();
          if (f > 0 && p == 1)
            chk(x_code == 16'(cal_m[1]), "R7 write during scan ignored", x_code, cal_m[1]);
          else
            chk(x_code == 16'(cal_m[p]), "R2 imaging code", x_code, cal_m[p]);
          chk(img_active === 1'b1, "R5 active in imaging", img_active, 1);
          chk(line_sync === (p == 0), "R4 line_sync", line_sync, p == 0);
          chk(frame_sync === (p == 0 && l == 0), "R4 frame_sync", frame_sync, p == 0 && l == 0);
          chk(y_code == 16'(exp_y(l)), "R6 y code", y_code, exp_y(l));
          if (p == 0) begin
            ex = x_code;
            repeat (3) @(negedge clk);
            chk(x_code == 16'(ex) && line_sync, "R8 hold without tick", x_code, ex);
          end
          if (f == 0 && l == 0 && p == 0 && pl >= 1) begin
            @(negedge clk) begin cal_we = 1'b1; cal_addr = 10'd1; cal_data = ~16'(cal_m[1]); end
            @(negedge clk) cal_we = 1'b0;
          end
          if (f == nf - 1 && l == 0 && p == 0) begin
            @(negedge clk) stop_req = 1'b1;
            @(negedge clk) stop_req = 1'b0;
            chk(running === 1'b1, "R9 stop deferred", running, 1);
          end
        end
        for (int k = 1; k <= (1 << sh); k++) begin
          tick_once();
          ex = exp_fly(cal_m[pl], cal_m[0], k, sh);
          chk(x_code == 16'(ex), "R3 flyback code", x_code, ex);
          chk(img_active === 1'b0 && line_sync === 1'b0, "R5 inactive in flyback", img_active, 0);
        end
      end
    end
    tick_once();
    chk(running === 1'b0, "R9 idle after frame", running, 0);
    chk(y_code == y_start, "R9 y parked", y_code, y_start);
    chk(x_code == 16'(cal_m[0]), "R9 x parked", x_code, cal_m[0]);
    tick_once();
    chk(running === 1'b0 && img_active === 1'b0, "R10 no restart without start", running, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c7));
    for (int i = 0; i < 1024; i++) cal_m[i] = i << 6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(running === 1'b0 && img_active === 1'b0, "R1 reset idle", running, 0);
    chk(line_sync === 1'b0 && frame_sync === 1'b0, "R1 reset syncs", line_sync, 0);
    chk(y_code == y_start, "R1 reset y", y_code, y_start);
    chk(x_code == 16'd0, "R1 reset table identity", x_code, 0);

    tick_once();
    chk(running === 1'b0, "R10 tick without start", running, 0);
    @(negedge clk) start = 1'b1;
    repeat (3) @(negedge clk);
    chk(running === 1'b0, "R10 start without tick", running, 0);
    start = 1'b0;

    run_cfg(1023, 0, 0, 1);
    run_cfg(0, 1, 1, 1);
    write_cal(0, 16'h1234);
    write_cal(2, 16'hF000);
    run_cfg(2, 0, 7, 1);

    for (int c = 0; c < 6; c++) begin
      int pl;
      pl = 1 + ($urandom % 15);
      y_start = 16'($urandom);
      y_step = 16'($urandom);
      for (int a = 0; a <= pl; a++) write_cal(a, $urandom & 16'hFFFF);
      run_cfg(pl, $urandom % 4, $urandom % 5, 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule